// File: doc/BRIEF.md
# Power-on strap latch sequencer

This block reads configuration straps from pins that later carry clocks. Once the supply-good input rises, every shared pin is kept in high impedance for a fixed window of reference-clock cycles, so that external pull resistors can settle each pin high or low. On the last edge of that window the levels on the strap pins are stored in configuration registers. From that same edge on, the output drivers are enabled and the configuration bus is flagged valid.

The captured bits are a 3-bit frequency index, a pin-mode bit and an output-swing bit. The pin-mode bit decides whether two further dual-purpose pins become clock outputs or stay as inputs. The frequency index is also translated into the default CPU clock frequency in kHz.

The stored bits hold until supply-good falls. Supply-good is the only clear. It acts asynchronously and its release is synchronized to the reference clock. A fall at any moment, including in the middle of the window, returns the block to the high-impedance sampling state.

Top module: `strap_seq`

## Requirements
- R1: While `pwr_good` is low, `pin_oe` is all zero, `cfg_valid` is 0, every configuration bit is 0 and `cpu_khz` is 0. The clear takes effect without waiting for a clock edge.
- R2: After `pwr_good` rises, `pin_oe` stays zero and `cfg_valid` stays 0 for exactly SYNC_STAGES + WIN_CYCLES rising clock edges. Both change on the edge that completes that count.
- R3: On the terminal edge, the strap pin values are stored. Pin bit 0 goes to frequency-index bit 0, bit 1 to index bit 1, bit 2 to index bit 2, bit 3 to `cfg_mode` and bit 4 to `cfg_swing`. For `cfg_swing`, 0 means 3.3 V swing and 1 means 2.5 V swing. Pin levels earlier in the window have no effect.
- R4: `cfg_valid` and the strap-pin enables `pin_oe[4:0]` rise in the same cycle.
- R5: The dual-purpose pin enables `pin_oe[6:5]` go high together with the others only if the captured mode bit is 1. If the captured mode bit is 0, they stay 0.
- R6: After capture, the configuration outputs do not change while `pwr_good` stays high, whatever the strap pins do.
- R7: A fall of `pwr_good` during the window or after capture clears the configuration. The next rise starts a fresh full window and a fresh capture.
- R8: When `cfg_valid` is 1, `cpu_khz` gives the default frequency for the index. The values for indices 0 to 7 are 50000, 75000, 83300, 68500, 55000, 75000, 60000 and 66800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply-good indication; low clears everything |
| pin_in | input | 5 | Levels seen on the strap pins |
| pin_oe | output | 7 | Output-driver enables; bits 4:0 are strap pins, bits 6:5 are dual-purpose pins |
| cfg_fsel | output | 3 | Captured frequency index |
| cfg_mode | output | 1 | Captured pin-mode bit |
| cfg_swing | output | 1 | Captured swing select (0 = 3.3 V, 1 = 2.5 V) |
| cfg_valid | output | 1 | Configuration captured and drivers enabled |
| cpu_khz | output | 17 | Default CPU frequency for the captured index, 0 when not valid |

## Verification
Two events can land in the same cycle. The first is a strap change one edge before the window closes, which coincides with the capture. The second is a supply-good fall just before the terminal edge, which coincides with the enable that would otherwise come. The scoreboard provokes the first by changing the pins right after the next-to-last edge, and expects the late value to be captured. It provokes the second by dropping supply-good at that same point, and expects no capture, drivers still off, and a complete fresh window on the next rise.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int STRAP_W = 5;
  localparam int PIN_W   = 7;
  localparam int KHZ_W   = 17;

  typedef enum logic [0:0] {
    ST_SAMPLE = 1'b0,
    ST_RUN    = 1'b1
  } seq_st_t;

  typedef struct packed {
    logic       swing;
    logic       mode;
    logic [2:0] fsel;
  } strap_cfg_t;

  function automatic strap_cfg_t pins_to_cfg(input logic [STRAP_W-1:0] pins);
    strap_cfg_t c;
    c.fsel  = pins[2:0];
    c.mode  = pins[3];
    c.swing = pins[4];
    return c;
  endfunction

  function automatic logic [KHZ_W-1:0] fsel_to_khz(input logic [2:0] idx);
    logic [KHZ_W-1:0] k;
    case (idx)
      3'd0:    k = KHZ_W'(50000);
      3'd1:    k = KHZ_W'(75000);
      3'd2:    k = KHZ_W'(83300);
      3'd3:    k = KHZ_W'(68500);
      3'd4:    k = KHZ_W'(55000);
      3'd5:    k = KHZ_W'(75000);
      3'd6:    k = KHZ_W'(60000);
      default: k = KHZ_W'(66800);
    endcase
    return k;
  endfunction

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh[STAGES-1];
endmodule

// File: rtl/strap_win_timer.sv
module strap_win_timer #(
  parameter int WIN_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic win_done
);
  localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign win_done = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (en && !win_done)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_stb,
  input  logic [STRAP_W-1:0] pins,
  output strap_cfg_t         cfg,
  output logic               valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      valid <= 1'b0;
    end else if (cap_stb && !valid) begin
      cfg   <= pins_to_cfg(pins);
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_oe_ctrl.sv
module strap_oe_ctrl
  import strap_pkg::*;
(
  input  logic             run,
  input  logic             mode,
  output logic [PIN_W-1:0] oe
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    if (i >= STRAP_W) begin : g_dual
      assign oe[i] = run & mode;
    end else begin : g_strap
      assign oe[i] = run;
    end
  end
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
#(
  parameter int WIN_CYCLES  = 28636,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               pwr_good,
  input  logic [STRAP_W-1:0] pin_in,
  output logic [PIN_W-1:0]   pin_oe,
  output logic [2:0]         cfg_fsel,
  output logic               cfg_mode,
  output logic               cfg_swing,
  output logic               cfg_valid,
  output logic [KHZ_W-1:0]   cpu_khz
);
  logic       rst_n;
  logic       win_done;
  logic       run;
  seq_st_t    st;
  strap_cfg_t cfg;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(pwr_good), .rst_n(rst_n)
  );

  strap_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(st == ST_SAMPLE), .win_done(win_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= ST_SAMPLE;
    else if (win_done) st <= ST_RUN;
  end

  assign run = (st == ST_RUN);

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap_stb(win_done), .pins(pin_in),
    .cfg(cfg), .valid(cfg_valid)
  );

  strap_oe_ctrl u_oe (
    .run(run), .mode(cfg.mode), .oe(pin_oe)
  );

  assign cfg_fsel  = cfg.fsel;
  assign cfg_mode  = cfg.mode;
  assign cfg_swing = cfg.swing;
  assign cpu_khz   = cfg_valid ? fsel_to_khz(cfg.fsel) : '0;
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
  parameter int WIN_CYCLES  = 28636,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       pwr_good,
  input logic [6:0] pin_oe,
  input logic [2:0] cfg_fsel,
  input logic       cfg_mode,
  input logic       cfg_swing,
  input logic       cfg_valid
);
  logic [31:0] edges;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)          edges <= '0;
    else if (edges != '1)   edges <= edges + 1'b1;
  end

  // R1: quiet while the supply is not good
  p_quiet_r1: assert property (@(posedge clk)
    !pwr_good |-> (pin_oe == '0 && !cfg_valid && cfg_fsel == '0 && !cfg_mode && !cfg_swing));

  // R2: the window length is measured with a counter, not a long $past
  p_window_r2: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(cfg_valid) |-> (edges == 32'(SYNC_STAGES + WIN_CYCLES)));

  // R4: drivers on only with valid configuration, and together with it
  p_oe_valid_r4: assert property (@(posedge clk) disable iff (!pwr_good)
    (pin_oe[4:0] == 5'h1f) == cfg_valid);

  // R5: dual-purpose pins driven only in the output mode
  p_dual_r5: assert property (@(posedge clk) disable iff (!pwr_good)
    (pin_oe[6:5] != 2'b00) |-> (cfg_mode && cfg_valid));

  // R6: captured bits frozen
  p_hold_r6: assert property (@(posedge clk) disable iff (!pwr_good)
    cfg_valid |=> (cfg_valid && $stable(cfg_fsel) && $stable(cfg_mode) && $stable(cfg_swing)));
endmodule

bind strap_seq strap_seq_chk #(.WIN_CYCLES(WIN_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .pwr_good(pwr_good), .pin_oe(pin_oe), .cfg_fsel(cfg_fsel),
  .cfg_mode(cfg_mode), .cfg_swing(cfg_swing), .cfg_valid(cfg_valid)
);

// File: tb/sim_strap_seq.sv
module sim_strap_seq;
  localparam int CLK_P = 10;
  localparam int WIN   = 16;
  localparam int SYNC  = 2;
  localparam int TERM  = SYNC + WIN;

  typedef struct packed {
    logic [6:0]  oe;
    logic        v;
    logic [2:0]  fs;
    logic        md;
    logic        sw;
    logic [16:0] khz;
  } exp_t;

  logic        clk = 1'b0;
  logic        pwr_good = 1'b0;
  logic [4:0]  pin_in = 5'h00;
  logic [6:0]  pin_oe;
  logic [2:0]  cfg_fsel;
  logic        cfg_mode, cfg_swing, cfg_valid;
  logic [16:0] cpu_khz;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic       m_valid = 1'b0;
  logic [4:0] m_cfg = 5'h00;

  always #(CLK_P/2) clk = ~clk;

  strap_seq #(.WIN_CYCLES(WIN), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .pwr_good(pwr_good), .pin_in(pin_in), .pin_oe(pin_oe),
    .cfg_fsel(cfg_fsel), .cfg_mode(cfg_mode), .cfg_swing(cfg_swing),
    .cfg_valid(cfg_valid), .cpu_khz(cpu_khz)
  );

  function automatic logic [16:0] ref_khz(input logic [2:0] i);
    int unsigned t[8] = '{50000, 75000, 83300, 68500, 55000, 75000, 60000, 66800};
    return 17'(t[i]);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // driver side: push what the requirements predict for the coming negedge
  task automatic push(input string tag);
    exp_t e;
    e.v   = m_valid;
    e.fs  = m_valid ? m_cfg[2:0] : 3'b000;
    e.md  = m_valid ? m_cfg[3] : 1'b0;
    e.sw  = m_valid ? m_cfg[4] : 1'b0;
    e.oe  = m_valid ? {m_cfg[3], m_cfg[3], 5'h1f} : 7'h00;
    e.khz = m_valid ? ref_khz(m_cfg[2:0]) : 17'd0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {pin_oe, cfg_valid, cfg_fsel, cfg_mode, cfg_swing, cpu_khz};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: oe=%b v=%b fs=%0d md=%b sw=%b khz=%0d expected oe=%b v=%b fs=%0d md=%b sw=%b khz=%0d",
                 t, a.oe, a.v, a.fs, a.md, a.sw, a.khz, e.oe, e.v, e.fs, e.md, e.sw, e.khz);
      end
    end
  end

  task automatic power_off(input string tag);
    pwr_good = 1'b0;
    m_valid  = 1'b0;
    m_cfg    = 5'h00;
    push(tag);
  endtask

  // drop_at = 0: no drop; otherwise supply falls right after that edge
  task automatic power_up(input logic [4:0] early, input logic [4:0] late, input int drop_at);
    pwr_good = 1'b1;
    pin_in   = early;
    push("R2 start");
    for (int k = 1; k <= TERM; k++) begin
      tick();
      if (k == drop_at) begin
        power_off("R7 drop in window");
        return;
      end
      if (k == TERM - 1) pin_in = late;
      if (k == TERM) begin
        m_valid = 1'b1;
        m_cfg   = late;
        push("R3 R4 R5 R8 capture");
      end else begin
        push("R2 window");
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) begin tick(); push("R1 reset"); end

    // R3: early value differs from late, swing=1 mode=0 index=5; R5 dual off
    power_up(5'b01010, 5'b10101, 0);
    // R6: wiggle pins after capture
    for (int i = 0; i < 6; i++) begin
      tick();
      pin_in = 5'(i * 7 + 3);
      push("R6 hold");
    end
    // R7: drop after capture, async clear (R1)
    tick();
    power_off("R7 R1 drop after run");
    tick(); push("R1 off");

    // mode=1 index=2 swing=0
    power_up(5'b11111, 5'b01010, 0);
    tick(); push("R5 dual on");
    tick(); power_off("R7 drop");
    tick(); push("R1 off");

    // R7: drop one edge before the terminal edge, then a fresh window
    power_up(5'b01111, 5'b01111, TERM - 1);
    for (int i = 0; i < 3; i++) begin tick(); push("R7 stays off"); end
    power_up(5'b00000, 5'b11111, 0);
    tick(); power_off("R7 drop");

    // R8: every index
    for (int idx = 0; idx < 8; idx++) begin
      tick();
      power_up(5'b00000, {idx[1], idx[0] ^ idx[2], 3'(idx)}, 0);
      tick(); push("R8 index");
      tick(); power_off("R7 drop");
    end

    tick();
    @(negedge clk); #1;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule